// File: doc/BRIEF.md
# Region-Based Write-Read Ordering Guard

This block sits between a pipelined processor and its data memory bus, where a load is normally allowed to go out ahead of an earlier store. It keeps track of stores that the processor has posted but that have not yet been issued on the bus. It raises a stall against any load that must not overtake one of them. A load is held back when it hits exactly the address of a pending store, wherever that address lies. It is also held back when the load and a pending store both fall inside one programmable protected window, even though their addresses differ.

The protected window is set by two 16-bit configuration words. The base word holds bits [21:6] of a 22-bit word address, so the base moves in steps of 64 words. The size word is a mask of the form 2^n-1 that widens the window from 64 words (mask 0x0000) in power-of-two steps up to 4M words (mask 0xFFFF). A word address belongs to the window when its bits [21:6] and the base agree in every bit where the mask is zero. The base must be aligned to the chosen size. Both words are written through a one-cycle write strobe with a select bit, and the selected word can be read back.

Pending stores wait in a two-entry first-in first-out queue. The bus side pops the oldest one with a one-cycle issue strobe. The stall output is combinational. It stays high as long as any older queued store still conflicts with the presented load.

Top module: `wr_order_guard`

## Requirements
- R1: After reset the base word reads 0x0100 and the size word reads 0x00FF, which makes the window cover word addresses 0x4000 to 0x7FFF. The store queue is empty, `wq_full` is 0 and no load is stalled.
- R2: With `cfg_we` high, `cfg_sel`=0 writes `cfg_wdata` to the base word and `cfg_sel`=1 writes the size word. `cfg_rdata` shows the word chosen by `cfg_sel`, and a written value takes effect from the next cycle.
- R3: A word address is in the window when ((addr[21:6] XOR base) AND NOT size) is zero. With size 0x0000 and base 0x0100 the window is exactly 0x4000 to 0x403F.
- R4: A load whose address is in the window is stalled while a queued store also lies in the window, even when the two addresses differ.
- R5: A load to the same word address as a queued store is stalled whether or not that address is in the window.
- R6: A load is not stalled by a queued store at a different address when the load and the store are not both in the window.
- R7: A stall stays high until every older conflicting store has been popped by `wr_issue`. It drops in the cycle after the last such pop, even if non-conflicting stores remain queued.
- R8: The queue holds two stores and pops them in the order they were pushed. `wq_full` is high with two stores queued. A push while full with no issue in the same cycle is dropped. A push and an issue in the same cycle while full are both taken.
- R9: `rd_stall` is 0 whenever `rd_req` is 0.
- R10: An issue strobe while the queue is empty has no effect.
- R11: A store pushed in the same cycle as a load is treated as younger than that load. It cannot stall the load in that cycle, but it does from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Word select: 0 base, 1 size mask |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Read-back of the selected configuration word |
| wr_push | input | 1 | Processor posts a store |
| wr_push_addr | input | 22 | Word address of the posted store |
| wr_issue | input | 1 | Oldest queued store has been issued on the bus |
| wq_full | output | 1 | Two stores are queued |
| rd_req | input | 1 | A load is presented |
| rd_addr | input | 22 | Word address of the load |
| rd_stall | output | 1 | Load must wait behind an older store |

## Verification
Two pairs of events can land in the same cycle. The first is a push and an issue on a full queue. The bench fills the queue, then raises both strobes together. It checks that `wq_full` stays high and that the new store, now the younger entry, still stalls a window load until both entries have drained. The second is a push together with a load. The bench raises `rd_req`, `wr_push` and a matching address in one cycle. It requires no stall in that cycle and a stall in the next, so the push is judged younger than the load. A configuration write with a load in the same cycle is also checked: the stall follows the old window until the clock edge and the new one after it.

// File: rtl/wog_pkg.sv
package wog_pkg;

  typedef enum logic {
    CFG_BASE = 1'b0,
    CFG_SIZE = 1'b1
  } cfg_word_e;

  // True when a and b agree on every bit that the don't-care mask leaves at zero.
  function automatic logic masked_equal(input logic [31:0] a,
                                        input logic [31:0] b,
                                        input logic [31:0] dont_care);
    return ((a ^ b) & ~dont_care) == 32'd0;
  endfunction

endpackage

// File: rtl/wog_cfg_regs.sv
module wog_cfg_regs #(
  parameter int          CFG_W    = 16,
  parameter logic [15:0] BASE_RST = 16'h0100,
  parameter logic [15:0] SIZE_RST = 16'h00FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] base_q,
  output logic [CFG_W-1:0] size_q,
  output logic [CFG_W-1:0] rdata
);
  import wog_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= CFG_W'(BASE_RST);
      size_q <= CFG_W'(SIZE_RST);
    end else if (we) begin
      if (cfg_word_e'(sel) == CFG_BASE) base_q <= wdata;
      else                              size_q <= wdata;
    end
  end

  assign rdata = (cfg_word_e'(sel) == CFG_BASE) ? base_q : size_q;

endmodule

// File: rtl/wog_wr_queue.sv
module wog_wr_queue #(
  parameter int ADDR_W = 22,
  parameter int DEPTH  = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [ADDR_W-1:0]            push_addr,
  input  logic                         pop,
  output logic [DEPTH-1:0]             ent_valid,
  output logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  output logic [CNT_W-1:0]             count,
  output logic                         full,
  output logic                         do_push,
  output logic                         do_pop
);

  logic [DEPTH-1:0][ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]             cnt_q, cnt_d, base_idx;

  assign do_pop   = pop && (cnt_q != '0);
  assign base_idx = do_pop ? cnt_q - CNT_W'(1) : cnt_q;
  assign do_push  = push && (base_idx != CNT_W'(DEPTH));

  always_comb begin
    addr_d = addr_q;
    if (do_pop) begin
      for (int i = 0; i < DEPTH - 1; i++) addr_d[i] = addr_q[i+1];
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (do_push && base_idx == CNT_W'(i)) addr_d[i] = push_addr;
    end
    cnt_d = base_idx + (do_push ? CNT_W'(1) : CNT_W'(0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_valid
      assign ent_valid[g] = cnt_q > CNT_W'(g);
    end
  endgenerate

  assign ent_addr = addr_q;
  assign count    = cnt_q;
  assign full     = cnt_q == CNT_W'(DEPTH);

endmodule

// File: rtl/wog_conflict.sv
module wog_conflict #(
  parameter int ADDR_W = 22,
  parameter int CFG_W  = 16,
  parameter int DEPTH  = 2
) (
  input  logic [CFG_W-1:0]             base,
  input  logic [CFG_W-1:0]             size,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [DEPTH-1:0]             ent_valid,
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  output logic                         rd_in_win,
  output logic [DEPTH-1:0]             same_hit,
  output logic [DEPTH-1:0]             win_hit,
  output logic [DEPTH-1:0]             conflict
);
  import wog_pkg::*;

  assign rd_in_win = masked_equal(32'(rd_addr[ADDR_W-1 -: CFG_W]),
                                  32'(base), 32'(size));

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic wr_in_win;
      assign wr_in_win   = masked_equal(32'(ent_addr[g][ADDR_W-1 -: CFG_W]),
                                        32'(base), 32'(size));
      assign same_hit[g] = ent_valid[g] && (ent_addr[g] == rd_addr);
      assign win_hit[g]  = ent_valid[g] && wr_in_win && rd_in_win;
      assign conflict[g] = same_hit[g] || win_hit[g];
    end
  endgenerate

endmodule

// File: rtl/wr_order_guard.sv
module wr_order_guard #(
  parameter int          ADDR_W   = 22,
  parameter int          CFG_W    = 16,
  parameter int          DEPTH    = 2,
  parameter logic [15:0] BASE_RST = 16'h0100,
  parameter logic [15:0] SIZE_RST = 16'h00FF,
  localparam int         CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              wr_push,
  input  logic [ADDR_W-1:0] wr_push_addr,
  input  logic              wr_issue,
  output logic              wq_full,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_stall
);

  logic [CFG_W-1:0]             base_q, size_q;
  logic [DEPTH-1:0]             ent_valid;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [CNT_W-1:0]             q_count;
  logic                         q_push, q_pop;
  logic                         rd_in_win;
  logic [DEPTH-1:0]             same_hit, win_hit, conflict;
  logic                         any_same, any_win;

  wog_cfg_regs #(
    .CFG_W(CFG_W), .BASE_RST(BASE_RST), .SIZE_RST(SIZE_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .base_q(base_q), .size_q(size_q), .rdata(cfg_rdata)
  );

  wog_wr_queue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(wr_push), .push_addr(wr_push_addr),
    .pop(wr_issue), .ent_valid(ent_valid), .ent_addr(ent_addr),
    .count(q_count), .full(wq_full), .do_push(q_push), .do_pop(q_pop)
  );

  wog_conflict #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .DEPTH(DEPTH)) u_match (
    .base(base_q), .size(size_q), .rd_addr(rd_addr),
    .ent_valid(ent_valid), .ent_addr(ent_addr), .rd_in_win(rd_in_win),
    .same_hit(same_hit), .win_hit(win_hit), .conflict(conflict)
  );

  assign any_same = |same_hit;
  assign any_win  = |win_hit;
  assign rd_stall = rd_req && (|conflict);

endmodule

// File: rtl/wog_checker.sv
module wog_checker #(
  parameter int ADDR_W = 22,
  parameter int CFG_W  = 16,
  parameter int DEPTH  = 2,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_sel,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic [CFG_W-1:0]  base_q,
  input logic [CFG_W-1:0]  size_q,
  input logic              wr_push,
  input logic              wr_issue,
  input logic              wq_full,
  input logic [CNT_W-1:0]  q_count,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              any_same,
  input logic              rd_stall
);

  assert_idle_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |-> !rd_stall);

  assert_same_addr_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && any_same |-> rd_stall);

  assert_base_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_sel |=> base_q == $past(cfg_wdata));

  assert_size_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_sel |=> size_q == $past(cfg_wdata));

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wq_full && wr_push && !wr_issue |=> wq_full && q_count == $past(q_count));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));

  assert_empty_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_count == '0 && wr_issue && !wr_push |=> q_count == '0);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_stall && !wr_issue && !cfg_we) ##1 (rd_req && $stable(rd_addr))
    |-> rd_stall);

endmodule

bind wr_order_guard wog_checker #(
  .ADDR_W(ADDR_W), .CFG_W(CFG_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .base_q(base_q), .size_q(size_q),
  .wr_push(wr_push), .wr_issue(wr_issue), .wq_full(wq_full),
  .q_count(q_count), .rd_req(rd_req), .rd_addr(rd_addr),
  .any_same(any_same), .rd_stall(rd_stall)
);

// File: tb/wr_order_guard_bench.sv
`timescale 1ns/1ps
module wr_order_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        wr_push, wr_issue, wq_full;
  logic [21:0] wr_push_addr;
  logic        rd_req, rd_stall;
  logic [21:0] rd_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench-side model of the configuration and the pending stores
  logic [15:0] m_base, m_size;
  logic [21:0] mq[$];

  always #5 clk = ~clk;

  wr_order_guard u_wr_order_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wr_push(wr_push),
    .wr_push_addr(wr_push_addr), .wr_issue(wr_issue), .wq_full(wq_full),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_stall(rd_stall)
  );

  function automatic bit in_win(input logic [21:0] a);
    // OR the size mask into both sides, then compare the 64-word block numbers
    return ((a >> 6) | 22'(m_size)) == (22'(m_base) | 22'(m_size));
  endfunction

  function automatic bit exp_stall(input logic [21:0] a);
    bit s = 0;
    foreach (mq[i]) if (mq[i] == a || (in_win(mq[i]) && in_win(a))) s = 1;
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic push(input logic [21:0] a);
    wr_push = 1; wr_push_addr = a;
    step();
    wr_push = 0;
    if (mq.size() < 2) mq.push_back(a);
  endtask

  task automatic issue();
    wr_issue = 1;
    step();
    wr_issue = 0;
    if (mq.size() > 0) void'(mq.pop_front());
  endtask

  task automatic push_issue(input logic [21:0] a);
    wr_push = 1; wr_push_addr = a; wr_issue = 1;
    step();
    wr_push = 0; wr_issue = 0;
    if (mq.size() > 0) void'(mq.pop_front());
    mq.push_back(a);
  endtask

  task automatic probe(input string req, input logic [21:0] a);
    rd_req = 1; rd_addr = a; #1;
    check(req, 32'(rd_stall), 32'(exp_stall(a)));
    rd_req = 0; #1;
  endtask

  task automatic cfg_write(input logic sel, input logic [15:0] v);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    step();
    cfg_we = 0;
    if (sel) m_size = v; else m_base = v;
  endtask

  task automatic t_reset();
    cfg_sel = 0; #1; check("R1 base reset", 32'(cfg_rdata), 32'h0100);
    cfg_sel = 1; #1; check("R1 size reset", 32'(cfg_rdata), 32'h00FF);
    check("R1 full reset", 32'(wq_full), 0);
    rd_req = 1; rd_addr = 22'h4000; #1;
    check("R1 no stall after reset", 32'(rd_stall), 0);
    rd_req = 0; #1;
    check("R9 idle no stall", 32'(rd_stall), 0);
  endtask

  task automatic t_window_default();
    push(22'h4010);
    probe("R4 both in window", 22'h7FF0);
    check("R4 expect stall", 32'(exp_stall(22'h7FF0)), 1);
    probe("R6 load above window", 22'h8000);
    probe("R6 load below window", 22'h3FFF);
    issue();
    probe("R7 released after issue", 22'h7FF0);
  endtask

  task automatic t_same_addr();
    push(22'h10000);
    probe("R5 same address outside window", 22'h10000);
    check("R5 expect stall", 32'(exp_stall(22'h10000)), 1);
    probe("R6 neighbour outside window", 22'h10001);
    issue();
  endtask

  task automatic t_depth();
    push(22'h4000);
    push(22'h200000);
    check("R8 full with two", 32'(wq_full), 1);
    push(22'h5000);                      // dropped: queue full, no issue
    probe("R7 head conflicts", 22'h6000);
    issue();
    check("R8 not full after one pop", 32'(wq_full), 0);
    probe("R8 dropped push left no entry", 22'h5000);
    check("R8 expect no stall", 32'(exp_stall(22'h5000)), 0);
    probe("R7 non-conflicting tail", 22'h6000);
    issue();
  endtask

  task automatic t_two_conflicts();
    push(22'h4000);
    push(22'h5000);
    probe("R7 two older stores", 22'h6000);
    issue();
    probe("R7 one older store left", 22'h6000);
    check("R7 expect still stalled", 32'(exp_stall(22'h6000)), 1);
    issue();
    probe("R7 all drained", 22'h6000);
  endtask

  task automatic t_small_window();
    cfg_write(1'b1, 16'h0000);
    cfg_sel = 1; #1; check("R2 size readback", 32'(cfg_rdata), 0);
    cfg_sel = 0; #1; check("R2 base readback", 32'(cfg_rdata), 32'h0100);
    push(22'h4000);
    probe("R3 top of 64-word window", 22'h403F);
    check("R3 expect stall", 32'(exp_stall(22'h403F)), 1);
    probe("R3 just past window", 22'h4040);
    check("R3 expect no stall", 32'(exp_stall(22'h4040)), 0);
    issue();
    cfg_write(1'b1, 16'h00FF);
  endtask

  task automatic t_push_issue_full();
    push(22'h4000);
    push(22'h300000);
    push_issue(22'h5000);
    check("R8 still full after push+issue", 32'(wq_full), 1);
    probe("R8 new tail conflicts", 22'h6000);
    issue();
    probe("R8 tail still pending", 22'h6000);
    issue();
    probe("R8 drained", 22'h6000);
  endtask

  task automatic t_read_with_push();
    rd_req = 1; rd_addr = 22'h4000;
    wr_push = 1; wr_push_addr = 22'h4000; #1;
    check("R11 same-cycle push is younger", 32'(rd_stall), 0);
    step();
    wr_push = 0; mq.push_back(22'h4000); #1;
    check("R11 stall from next cycle", 32'(rd_stall), 1);
    rd_req = 0;
    issue();
  endtask

  task automatic t_empty_issue();
    issue();
    issue();
    check("R10 empty issue full flag", 32'(wq_full), 0);
    push(22'h4000);
    probe("R10 queue intact after empty issues", 22'h4000);
    check("R10 expect stall", 32'(exp_stall(22'h4000)), 1);
    issue();
    probe("R10 drained", 22'h4000);
  endtask

  task automatic t_cfg_timing();
    push(22'h9000);
    rd_req = 1; rd_addr = 22'h9040;
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 16'h0200; #1;
    check("R2 old window during write", 32'(rd_stall), 0);
    step();
    cfg_we = 0; m_base = 16'h0200; #1;
    check("R2 new window after write", 32'(rd_stall), 1);
    rd_req = 0;
    cfg_write(1'b0, 16'h0100);
    issue();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = '0;
    wr_push = 0; wr_push_addr = '0; wr_issue = 0; rd_req = 0; rd_addr = '0;
    m_base = 16'h0100; m_size = 16'h00FF;
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_window_default();
    t_same_addr();
    t_depth();
    t_two_conflicts();
    t_small_window();
    t_push_issue_full();
    t_read_with_push();
    t_empty_issue();
    t_cfg_timing();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule